// File: doc/BRIEF.md
# Compressed Instruction Expander

This block is purely combinational. It accepts one fetched instruction word and, when the low two bits mark it as a 16-bit compressed encoding of the 64-bit base integer set, rewrites it into the equivalent full-length 32-bit instruction. Immediate bits that the short form scatters are gathered back into place. Register fields of three bits are widened to full register numbers. Each encoding's reserved combinations (zero destination, zero immediate, zero shift amount) are reported on a separate illegal flag.

A decode stage places it between fetch and the main decoder. Full-length words pass straight through. A second output tells the pipeline whether the word it holds is a short one, so that the program counter can advance by two or by four. The short floating-point loads and stores are not supported and come back flagged illegal.

Top module: `rvc_expander`

## Requirements
- R1: When instr_i[1:0] is 2'b11 the word passes to instr_o unchanged, with is_compressed_o low and illegal_o low. Otherwise is_compressed_o is high, and every legal expansion ends in 2'b11.
- R2: The all-zero halfword is illegal. Whenever illegal_o is high, instr_o is all zeros.
- R3: Quadrant 0 (bits [1:0]=00) funct3 000 becomes addi rd', x2, imm. The immediate is unsigned and a multiple of 4, with bits [5:4]=h[12:11], [9:6]=h[10:7], [2]=h[6], [3]=h[5]. A zero immediate is illegal. A 3-bit register field r denotes register 8+r.
- R4: Quadrant 0 funct3 010/011 give lw/ld rd'=h[4:2] from rs1'=h[9:7], and 110/111 give sw/sd of rs2'=h[4:2]. The word offset is {h[5],h[12:10],h[6],2'b0}. The doubleword offset is h[12:10]<<3 | h[6:5]<<6. Quadrant 0 funct3 001, 100 and 101, and quadrant 2 funct3 001 and 101, are illegal.
- R5: Quadrant 1 funct3 000 is addi rd, rd, simm6, where simm6 = sign-extended {h[12],h[6:2]}. It is legal only when rd=h[11:7] is zero exactly when the immediate is zero.
- R6: Quadrant 1 funct3 001 (addiw rd, rd, simm6) and 010 (addi rd, x0, simm6) are illegal with rd = x0.
- R7: In quadrant 1 funct3 011 with rd=x2, the result is addi x2, x2, imm. The immediate is a sign-extended 10-bit value in steps of 16, built from bits [9]=h[12], [8:7]=h[4:3], [6]=h[5], [5]=h[2], [4]=h[6]. With any other rd the result is lui rd, simm6. Illegal cases: a zero stack-adjust value, lui with rd=x0, and lui with a zero immediate.
- R8: Quadrant 1 funct3 100 uses h[11:10]. Value 00 gives srli and 01 gives srai on rd'=h[9:7], with the 6-bit amount {h[12],h[6:2]}; a zero amount is illegal. Value 10 gives andi with simm6.
- R9: Quadrant 1 funct3 100 with h[11:10]=11 gives register-register ops on rd'/rs2'. With h[12]=0, h[6:5] selects sub, xor, or, and. With h[12]=1, it selects subw (00) or addw (01); 10 and 11 are illegal.
- R10: Quadrant 1 funct3 101 is jal x0 with a sign-extended 12-bit offset. Funct3 110 and 111 are beq and bne of rs1'=h[9:7] against x0, with a sign-extended 9-bit offset.
- R11: Quadrant 2 funct3 000 is slli rd, rd, amount; rd=x0 or a zero amount is illegal. Funct3 010/011 are lw/ld from x2, with offsets scaled by 4 and by 8; rd=x0 is illegal. Funct3 110/111 are sw/sd of rs2=h[6:2] relative to x2.
- R12: In quadrant 2 with h[15:12]=1000: if rs2=h[6:2] is zero, the result is jalr x0, 0(rs1=h[11:7]), which is illegal when rs1 is x0. Otherwise the result is add rd, x0, rs2, which is illegal when rd is x0.
- R13: In quadrant 2 with h[15:12]=1001: if h[11:7] and h[6:2] are both zero, the result is ebreak (32'h00100073). If only rs2 is zero, the result is jalr x1, 0(rs1). Otherwise the result is add rd, rd, rs2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Fetched word; only bits [15:0] matter for a short encoding |
| instr_o | output | 32 | Expanded or passed-through instruction, zero when illegal |
| is_compressed_o | output | 1 | High when the input is a 16-bit encoding |
| illegal_o | output | 1 | High when the short encoding is reserved or unsupported |

## Verification
The hardest behaviour to reach from the ports is the set of single-code and single-field corners. Examples are the ebreak pattern, addi with a zero destination but a non-zero immediate, lui aimed at x2 turning into a stack adjust, and the reserved word-arithmetic selectors. Random stimulus reaches each of these only rarely. The bench therefore sweeps every one of the 65,536 halfword values once, so each reserved combination and each immediate bit position is met. It then adds random full-length words for the pass-through path. A behavioural model that rebuilds every immediate by integer weighting checks the outputs of each pattern.

// File: rtl/rvc_expander_pkg.sv
package rvc_expander_pkg;

  localparam int ILEN = 32;
  localparam int CLEN = 16;
  localparam int RW   = 5;

  typedef logic [ILEN-1:0] word_t;
  typedef logic [CLEN-1:0] half_t;
  typedef logic [RW-1:0]   reg_t;

  typedef struct packed {
    word_t word;
    logic  bad;
  } xlat_t;

  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_IMM32  = 7'b0011011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_REG32  = 7'b0111011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam word_t      WORD_EBRK  = 32'h0010_0073;
  localparam reg_t       REG_ZERO   = 5'd0;
  localparam reg_t       REG_RA     = 5'd1;
  localparam reg_t       REG_SP     = 5'd2;

  // three-bit register field -> x8..x15
  function automatic reg_t creg(input logic [2:0] r);
    return {2'b01, r};
  endfunction

  // ---------------- encoders ----------------
  function automatic word_t enc_i(input logic [11:0] imm, input reg_t rs1,
                                  input logic [2:0] f3, input reg_t rd,
                                  input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic word_t enc_s(input logic [11:0] imm, input reg_t rs2,
                                  input reg_t rs1, input logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
  endfunction

  function automatic word_t enc_r(input logic [6:0] f7, input reg_t rs2,
                                  input reg_t rs1, input logic [2:0] f3,
                                  input reg_t rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic word_t enc_u(input logic [19:0] up, input reg_t rd);
    return {up, rd, OPC_LUI};
  endfunction

  // o holds offset bits [20:1]
  function automatic word_t enc_j(input logic [19:0] o, input reg_t rd);
    return {o[19], o[9:0], o[10], o[18:11], rd, OPC_JAL};
  endfunction

  // o holds offset bits [12:1]
  function automatic word_t enc_b(input logic [11:0] o, input reg_t rs1,
                                  input logic [2:0] f3);
    return {o[11], o[9:4], REG_ZERO, rs1, f3, o[3:0], o[10], OPC_BRANCH};
  endfunction

  // ---------------- immediate gathering ----------------
  function automatic logic [11:0] imm_spadd4(input half_t h);
    return {2'b00, h[10:7], h[12:11], h[5], h[6], 2'b00};
  endfunction

  function automatic logic [11:0] imm_word_mem(input half_t h);
    return {5'b0, h[5], h[12:10], h[6], 2'b00};
  endfunction

  function automatic logic [11:0] imm_dword_mem(input half_t h);
    return {4'b0, h[6:5], h[12:10], 3'b000};
  endfunction

  function automatic logic [11:0] imm_s6(input half_t h);
    return {{6{h[12]}}, h[12], h[6:2]};
  endfunction

  function automatic logic [19:0] imm_upper(input half_t h);
    return {{14{h[12]}}, h[12], h[6:2]};
  endfunction

  function automatic logic [11:0] imm_spadj16(input half_t h);
    return {{2{h[12]}}, h[12], h[4:3], h[5], h[2], h[6], 4'b0000};
  endfunction

  function automatic logic [5:0] shamt6(input half_t h);
    return {h[12], h[6:2]};
  endfunction

  function automatic logic [19:0] off_jump(input half_t h);
    return {{9{h[12]}}, h[12], h[8], h[10:9], h[6], h[7], h[2], h[11], h[5:3]};
  endfunction

  function automatic logic [11:0] off_branch(input half_t h);
    return {{4{h[12]}}, h[12], h[6:5], h[2], h[11:10], h[4:3]};
  endfunction

  function automatic logic [11:0] imm_sp_wload(input half_t h);
    return {4'b0, h[3:2], h[12], h[6:4], 2'b00};
  endfunction

  function automatic logic [11:0] imm_sp_dload(input half_t h);
    return {3'b0, h[4:2], h[12], h[6:5], 3'b000};
  endfunction

  function automatic logic [11:0] imm_sp_wstore(input half_t h);
    return {4'b0, h[8:7], h[12:9], 2'b00};
  endfunction

  function automatic logic [11:0] imm_sp_dstore(input half_t h);
    return {3'b0, h[9:7], h[12:10], 3'b000};
  endfunction

endpackage

// File: rtl/rvc_quad0.sv
module rvc_quad0
  import rvc_expander_pkg::*;
(
  input  half_t half,
  output xlat_t res
);
  reg_t rd_c;
  reg_t rs_c;

  assign rd_c = creg(half[4:2]);
  assign rs_c = creg(half[9:7]);

  always_comb begin
    res.word = '0;
    res.bad  = 1'b1;
    unique case (half[15:13])
      3'b000: begin
        res.word = enc_i(imm_spadd4(half), REG_SP, 3'b000, rd_c, OPC_IMM);
        res.bad  = (imm_spadd4(half) == 12'd0);
      end
      3'b010: begin
        res.word = enc_i(imm_word_mem(half), rs_c, 3'b010, rd_c, OPC_LOAD);
        res.bad  = 1'b0;
      end
      3'b011: begin
        res.word = enc_i(imm_dword_mem(half), rs_c, 3'b011, rd_c, OPC_LOAD);
        res.bad  = 1'b0;
      end
      3'b110: begin
        res.word = enc_s(imm_word_mem(half), rd_c, rs_c, 3'b010);
        res.bad  = 1'b0;
      end
      3'b111: begin
        res.word = enc_s(imm_dword_mem(half), rd_c, rs_c, 3'b011);
        res.bad  = 1'b0;
      end
      default: begin
        res.word = '0;
        res.bad  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/rvc_quad1.sv
module rvc_quad1
  import rvc_expander_pkg::*;
(
  input  half_t half,
  output xlat_t res
);
  reg_t        rd_f;
  reg_t        rdp;
  reg_t        rs2p;
  logic [11:0] simm;
  logic [5:0]  sh;
  logic        imm_zero;
  logic [2:0]  alu_f3;

  assign rd_f     = half[11:7];
  assign rdp      = creg(half[9:7]);
  assign rs2p     = creg(half[4:2]);
  assign simm     = imm_s6(half);
  assign sh       = shamt6(half);
  assign imm_zero = (sh == 6'd0);

  always_comb begin
    unique case (half[6:5])
      2'b00:   alu_f3 = 3'b000;
      2'b01:   alu_f3 = 3'b100;
      2'b10:   alu_f3 = 3'b110;
      default: alu_f3 = 3'b111;
    endcase
  end

  always_comb begin
    res.word = '0;
    res.bad  = 1'b1;
    unique case (half[15:13])
      3'b000: begin
        res.word = enc_i(simm, rd_f, 3'b000, rd_f, OPC_IMM);
        res.bad  = ((rd_f == REG_ZERO) != imm_zero);
      end
      3'b001: begin
        res.word = enc_i(simm, rd_f, 3'b000, rd_f, OPC_IMM32);
        res.bad  = (rd_f == REG_ZERO);
      end
      3'b010: begin
        res.word = enc_i(simm, REG_ZERO, 3'b000, rd_f, OPC_IMM);
        res.bad  = (rd_f == REG_ZERO);
      end
      3'b011: begin
        if (rd_f == REG_SP) begin
          res.word = enc_i(imm_spadj16(half), REG_SP, 3'b000, REG_SP, OPC_IMM);
          res.bad  = (imm_spadj16(half) == 12'd0);
        end else begin
          res.word = enc_u(imm_upper(half), rd_f);
          res.bad  = (rd_f == REG_ZERO) || imm_zero;
        end
      end
      3'b100: begin
        unique case (half[11:10])
          2'b00: begin
            res.word = enc_i({6'b000000, sh}, rdp, 3'b101, rdp, OPC_IMM);
            res.bad  = imm_zero;
          end
          2'b01: begin
            res.word = enc_i({6'b010000, sh}, rdp, 3'b101, rdp, OPC_IMM);
            res.bad  = imm_zero;
          end
          2'b10: begin
            res.word = enc_i(simm, rdp, 3'b111, rdp, OPC_IMM);
            res.bad  = 1'b0;
          end
          default: begin
            if (!half[12]) begin
              res.word = enc_r((half[6:5] == 2'b00) ? 7'b0100000 : 7'b0000000,
                               rs2p, rdp, alu_f3, rdp, OPC_REG);
              res.bad  = 1'b0;
            end else if (!half[6]) begin
              res.word = enc_r(half[5] ? 7'b0000000 : 7'b0100000,
                               rs2p, rdp, 3'b000, rdp, OPC_REG32);
              res.bad  = 1'b0;
            end else begin
              res.word = '0;
              res.bad  = 1'b1;
            end
          end
        endcase
      end
      3'b101: begin
        res.word = enc_j(off_jump(half), REG_ZERO);
        res.bad  = 1'b0;
      end
      3'b110: begin
        res.word = enc_b(off_branch(half), rdp, 3'b000);
        res.bad  = 1'b0;
      end
      default: begin
        res.word = enc_b(off_branch(half), rdp, 3'b001);
        res.bad  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rvc_quad2.sv
module rvc_quad2
  import rvc_expander_pkg::*;
(
  input  half_t half,
  output xlat_t res
);
  reg_t       rd_f;
  reg_t       rs2_f;
  logic [5:0] sh;

  assign rd_f  = half[11:7];
  assign rs2_f = half[6:2];
  assign sh    = shamt6(half);

  always_comb begin
    res.word = '0;
    res.bad  = 1'b1;
    unique case (half[15:13])
      3'b000: begin
        res.word = enc_i({6'b000000, sh}, rd_f, 3'b001, rd_f, OPC_IMM);
        res.bad  = (rd_f == REG_ZERO) || (sh == 6'd0);
      end
      3'b010: begin
        res.word = enc_i(imm_sp_wload(half), REG_SP, 3'b010, rd_f, OPC_LOAD);
        res.bad  = (rd_f == REG_ZERO);
      end
      3'b011: begin
        res.word = enc_i(imm_sp_dload(half), REG_SP, 3'b011, rd_f, OPC_LOAD);
        res.bad  = (rd_f == REG_ZERO);
      end
      3'b100: begin
        if (!half[12]) begin
          if (rs2_f == REG_ZERO) begin
            res.word = enc_i(12'd0, rd_f, 3'b000, REG_ZERO, OPC_JALR);
            res.bad  = (rd_f == REG_ZERO);
          end else begin
            res.word = enc_r(7'd0, rs2_f, REG_ZERO, 3'b000, rd_f, OPC_REG);
            res.bad  = (rd_f == REG_ZERO);
          end
        end else begin
          if ((rs2_f == REG_ZERO) && (rd_f == REG_ZERO)) begin
            res.word = WORD_EBRK;
            res.bad  = 1'b0;
          end else if (rs2_f == REG_ZERO) begin
            res.word = enc_i(12'd0, rd_f, 3'b000, REG_RA, OPC_JALR);
            res.bad  = 1'b0;
          end else begin
            res.word = enc_r(7'd0, rs2_f, rd_f, 3'b000, rd_f, OPC_REG);
            res.bad  = 1'b0;
          end
        end
      end
      3'b110: begin
        res.word = enc_s(imm_sp_wstore(half), rs2_f, REG_SP, 3'b010);
        res.bad  = 1'b0;
      end
      3'b111: begin
        res.word = enc_s(imm_sp_dstore(half), rs2_f, REG_SP, 3'b011);
        res.bad  = 1'b0;
      end
      default: begin
        res.word = '0;
        res.bad  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
  import rvc_expander_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [31:0] instr_o,
  output logic        is_compressed_o,
  output logic        illegal_o
);
  half_t half;
  xlat_t res_q0;
  xlat_t res_q1;
  xlat_t res_q2;
  xlat_t sel;
  logic  wide_word;
  logic  zero_half;

  assign half      = instr_i[CLEN-1:0];
  assign wide_word = (instr_i[1:0] == 2'b11);
  assign zero_half = (half == '0);

  rvc_quad0 u_q0 (.half(half), .res(res_q0));
  rvc_quad1 u_q1 (.half(half), .res(res_q1));
  rvc_quad2 u_q2 (.half(half), .res(res_q2));

  always_comb begin
    unique case (instr_i[1:0])
      2'b00:   sel = res_q0;
      2'b01:   sel = res_q1;
      2'b10:   sel = res_q2;
      default: sel = '{word: instr_i, bad: 1'b0};
    endcase
  end

  assign is_compressed_o = !wide_word;
  assign illegal_o       = !wide_word && sel.bad;
  assign instr_o         = wide_word ? instr_i : (sel.bad ? '0 : sel.word);
endmodule

// File: rtl/rvc_expander_chk.sv
module rvc_expander_chk (
  input logic [31:0] instr_i,
  input logic [31:0] instr_o,
  input logic        is_compressed_o,
  input logic        illegal_o,
  input logic        zero_half
);
  always_comb begin
    if (instr_i[1:0] == 2'b11) begin
      p_wide_pass_r1: assert ((instr_o == instr_i) && !illegal_o && !is_compressed_o)
        else $error("wide word altered");
    end
    if (is_compressed_o && !illegal_o) begin
      p_full_len_r1: assert (instr_o[1:0] == 2'b11)
        else $error("expansion lacks full-length marker");
    end
    if (zero_half) begin
      p_zero_half_r2: assert (illegal_o)
        else $error("zero halfword accepted");
    end
    if (illegal_o) begin
      p_blank_bad_r2: assert ((instr_o == 32'd0) && is_compressed_o)
        else $error("illegal output not blanked");
    end
    if (is_compressed_o && !illegal_o && (instr_i[1:0] == 2'b00) &&
        (instr_i[15:13] != 3'b110) && (instr_i[15:13] != 3'b111)) begin
      p_narrow_reg_r3: assert (instr_o[11:10] == 2'b01)
        else $error("narrow register outside x8..x15");
    end
    if (instr_i[15:0] == 16'h9002) begin
      p_break_code_r13: assert (instr_o == 32'h0010_0073)
        else $error("ebreak mis-expanded");
    end
  end
endmodule

bind rvc_expander rvc_expander_chk u_chk (
  .instr_i        (instr_i),
  .instr_o        (instr_o),
  .is_compressed_o(is_compressed_o),
  .illegal_o      (illegal_o),
  .zero_half      (zero_half)
);

// File: tb/test_rvc_expander.sv
`timescale 1ns/1ps
module test_rvc_expander;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr;
  logic [31:0] instr_o;
  logic        is_c;
  logic        ill;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  logic [31:0] stim_q[$];

  always #4 clk = ~clk;

  rvc_expander i_rvc_expander (
    .instr_i(instr), .instr_o(instr_o),
    .is_compressed_o(is_c), .illegal_o(ill)
  );

  function automatic int fld(input logic [15:0] h, input int hi, input int lo);
    return int'((h >> lo) & ((1 << (hi - lo + 1)) - 1));
  endfunction

  function automatic int sx(input int v, input int n);
    return (v >= (1 << (n - 1))) ? v - (1 << n) : v;
  endfunction

  function automatic logic [31:0] ei(int imm, int rs1, int f3, int rd, int op);
    return ((imm & 'hfff) << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op;
  endfunction

  function automatic logic [31:0] es(int imm, int rs2, int rs1, int f3);
    return (((imm >> 5) & 'h7f) << 25) | (rs2 << 20) | (rs1 << 15) |
           (f3 << 12) | ((imm & 'h1f) << 7) | 'h23;
  endfunction

  function automatic logic [31:0] er(int f7, int rs2, int rs1, int f3, int rd, int op);
    return (f7 << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op;
  endfunction

  function automatic logic [31:0] ej(int off);
    return (((off >> 20) & 1) << 31) | (((off >> 1) & 'h3ff) << 21) |
           (((off >> 11) & 1) << 20) | (((off >> 12) & 'hff) << 12) | 'h6f;
  endfunction

  function automatic logic [31:0] eb(int off, int rs1, int f3);
    return (((off >> 12) & 1) << 31) | (((off >> 5) & 'h3f) << 25) |
           (rs1 << 15) | (f3 << 12) | (((off >> 1) & 'hf) << 8) |
           (((off >> 11) & 1) << 7) | 'h63;
  endfunction

  // behavioural reference: integer-weighted immediates, table of rules
  function automatic void model(input logic [31:0] w, output logic [31:0] ew,
                                output bit eill, output bit ecmp, output string tag);
    logic [15:0] h = w[15:0];
    int q = fld(h, 1, 0), f3 = fld(h, 15, 13);
    int r1 = fld(h, 11, 7), r2 = fld(h, 6, 2);
    int p1 = 8 + fld(h, 9, 7), p2 = 8 + fld(h, 4, 2);
    int ci = sx(fld(h, 12, 12) * 32 + r2, 6);
    int sh = fld(h, 12, 12) * 32 + r2;
    int v;
    ecmp = (q != 3);
    eill = 1'b1;
    ew = 32'd0;
    tag = "R4";
    if (!ecmp) begin
      ew = w; eill = 1'b0; tag = "R1";
      return;
    end
    if (q == 0) begin
      case (f3)
        0: begin
          tag = (h == 0) ? "R2" : "R3";
          v = fld(h,12,11)*16 + fld(h,10,7)*64 + fld(h,6,6)*4 + fld(h,5,5)*8;
          if (v != 0) begin ew = ei(v, 2, 0, p2, 'h13); eill = 0; end
        end
        2, 6: begin
          v = fld(h,12,10)*8 + fld(h,6,6)*4 + fld(h,5,5)*64;
          ew = (f3 == 2) ? ei(v, p1, 2, p2, 3) : es(v, p2, p1, 2); eill = 0;
        end
        3, 7: begin
          v = fld(h,12,10)*8 + fld(h,6,5)*64;
          ew = (f3 == 3) ? ei(v, p1, 3, p2, 3) : es(v, p2, p1, 3); eill = 0;
        end
        default: tag = "R4";
      endcase
    end else if (q == 1) begin
      case (f3)
        0: begin tag = "R5"; if ((r1 == 0) == (ci == 0)) begin ew = ei(ci, r1, 0, r1, 'h13); eill = 0; end end
        1: begin tag = "R6"; if (r1 != 0) begin ew = ei(ci, r1, 0, r1, 'h1b); eill = 0; end end
        2: begin tag = "R6"; if (r1 != 0) begin ew = ei(ci, 0, 0, r1, 'h13); eill = 0; end end
        3: begin
          tag = "R7";
          if (r1 == 2) begin
            v = sx(fld(h,12,12)*512 + fld(h,4,3)*128 + fld(h,5,5)*64 +
                   fld(h,2,2)*32 + fld(h,6,6)*16, 10);
            if (v != 0) begin ew = ei(v, 2, 0, 2, 'h13); eill = 0; end
          end else if (r1 != 0 && ci != 0) begin
            ew = ((ci & 'hfffff) << 12) | (r1 << 7) | 'h37; eill = 0;
          end
        end
        4: begin
          case (fld(h, 11, 10))
            0: begin tag = "R8"; if (sh != 0) begin ew = ei(sh, p1, 5, p1, 'h13); eill = 0; end end
            1: begin tag = "R8"; if (sh != 0) begin ew = ei(sh + 1024, p1, 5, p1, 'h13); eill = 0; end end
            2: begin tag = "R8"; ew = ei(ci, p1, 7, p1, 'h13); eill = 0; end
            default: begin
              tag = "R9";
              if (fld(h, 12, 12) == 0) begin
                case (fld(h, 6, 5))
                  0: ew = er('h20, p2, p1, 0, p1, 'h33);
                  1: ew = er(0, p2, p1, 4, p1, 'h33);
                  2: ew = er(0, p2, p1, 6, p1, 'h33);
                  default: ew = er(0, p2, p1, 7, p1, 'h33);
                endcase
                eill = 0;
              end else if (fld(h, 6, 5) < 2) begin
                ew = er(fld(h, 5, 5) ? 0 : 'h20, p2, p1, 0, p1, 'h3b); eill = 0;
              end
            end
          endcase
        end
        5: begin
          tag = "R10";
          v = sx(fld(h,12,12)*2048 + fld(h,11,11)*16 + fld(h,10,9)*256 + fld(h,8,8)*1024 +
                 fld(h,7,7)*64 + fld(h,6,6)*128 + fld(h,5,3)*2 + fld(h,2,2)*32, 12);
          ew = ej(v); eill = 0;
        end
        default: begin
          tag = "R10";
          v = sx(fld(h,12,12)*256 + fld(h,11,10)*8 + fld(h,6,5)*64 +
                 fld(h,4,3)*2 + fld(h,2,2)*32, 9);
          ew = eb(v, p1, (f3 == 6) ? 0 : 1); eill = 0;
        end
      endcase
    end else begin
      case (f3)
        0: begin tag = "R11"; if (r1 != 0 && sh != 0) begin ew = ei(sh, r1, 1, r1, 'h13); eill = 0; end end
        2: begin
          tag = "R11"; v = fld(h,12,12)*32 + fld(h,6,4)*4 + fld(h,3,2)*64;
          if (r1 != 0) begin ew = ei(v, 2, 2, r1, 3); eill = 0; end
        end
        3: begin
          tag = "R11"; v = fld(h,12,12)*32 + fld(h,6,5)*8 + fld(h,4,2)*64;
          if (r1 != 0) begin ew = ei(v, 2, 3, r1, 3); eill = 0; end
        end
        4: begin
          if (fld(h, 12, 12) == 0) begin
            tag = "R12";
            if (r1 != 0) begin
              ew = (r2 == 0) ? ei(0, r1, 0, 0, 'h67) : er(0, r2, 0, 0, r1, 'h33); eill = 0;
            end
          end else begin
            tag = "R13"; eill = 0;
            if (r1 == 0 && r2 == 0) ew = 32'h0010_0073;
            else if (r2 == 0)       ew = ei(0, r1, 0, 1, 'h67);
            else                    ew = er(0, r2, r1, 0, r1, 'h33);
          end
        end
        6: begin tag = "R11"; v = fld(h,12,9)*4 + fld(h,8,7)*64; ew = es(v, r2, 2, 2); eill = 0; end
        7: begin tag = "R11"; v = fld(h,12,10)*8 + fld(h,9,7)*64; ew = es(v, r2, 2, 3); eill = 0; end
        default: tag = "R4";
      endcase
    end
  endfunction

  task automatic compare(input logic [31:0] w);
    logic [31:0] ew;
    bit eill, ecmp;
    string tag;
    model(w, ew, eill, ecmp, tag);
    checks++;
    if (instr_o !== ew || ill !== eill || is_c !== ecmp) begin
      fails++;
      $display("FAIL %s in=%h actual word=%h ill=%0d cmp=%0d expected word=%h ill=%0d cmp=%0d",
               tag, w, instr_o, ill, is_c, ew, eill, ecmp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    instr = 32'd0;
    repeat (3) @(posedge clk);
    // reset state: zero input must read as illegal, blank output (R2)
    compare(32'd0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 65536; i++) stim_q.push_back({16'hBEEF ^ 16'(i * 7), 16'(i)});
    for (int i = 0; i < 2000; i++) stim_q.push_back({$urandom} | 32'h3);
    while (stim_q.size() > 0) begin
      @(negedge clk);
      instr = stim_q.pop_front();
      @(posedge clk);
      compare(instr);
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule